// File: doc/BRIEF.md
# PAE Root-Table Validity Checker

This block runs once at the start of a virtual-machine entry. It decides whether the four root paging entries of a guest that uses 32-bit PAE paging have to be validated. When they do, it validates them and reports the result. A single `start` pulse presents a snapshot of the guest and control state: CR4, the 64-bit-guest entry control, the primary and secondary execution-control words, the old and new CR3 values, a flag that PAE paging was already active, and the physical-address width.

The block chooses one of three routes:

- **Pass.** No check is needed, so it reports a pass.
- **Fields.** Nested paging is effectively on, so it checks the four entries supplied as guest-state fields.
- **Memory.** It fetches the four entries, one at a time, from a read port addressed by the new CR3 and checks them as they arrive.

Completion is a one-cycle `done` strobe, with `fail` valid in that same cycle. A new `start` is ignored until the current check has finished.

Top module: `pae_root_check`

## Requirements
- R1: After a synchronous reset, `done`, `fail` and `rd_req_valid` are all 0.
- R2: If `guest_cr4` bit 5 is 0, or `ia32e_guest` is 1, an accepted start gives `done`=1 with `fail`=0 in the cycle after the start edge, and no read is issued.
- R3: Nested paging counts as enabled only when `prim_ctl` bit 31 and `sec_ctl` bit 1 are both 1. When it is enabled and R2 does not apply, the four `gs_ent` entries are checked, no read is issued, and `done` rises in the cycle after the start edge.
- R4: When nested paging is not enabled, R2 does not apply, and either `pae_was_active` is 0 or `cr3_old` differs from `cr3_new`, four reads are issued in order. They go to base, base+8, base+16 and base+24, where base is `cr3_new` bits 31:5 followed by five zero bits. Only one read is outstanding at a time.
- R5: When nested paging is not enabled, `pae_was_active` is 1 and `cr3_old` equals `cr3_new`, the result is a pass in the cycle after the start edge, and no read is issued.
- R6: An entry whose bit 0 is 0 is valid, whatever its other bits hold.
- R7: In a present entry, bits 4:3 and 11:9 may take any value.
- R8: A present entry with any of bits 2:1 or 8:5 set is invalid.
- R9: A present entry is invalid if any bit at or above max(`pa_width`, 12) is set, up to bit 63. Set bits below that limit, in the range from bit 12 up, are allowed.
- R10: In the memory route, `done` is high for exactly the one cycle after the edge that accepts the fourth response. `fail` is high only together with `done`, and it is 1 exactly when at least one of the four entries is invalid.
- R11: A start while a memory-route check is in progress produces no extra `done` and does not disturb the check in progress.
- R12: While `rd_req_valid` is 1 and `rd_req_ready` is 0, `rd_req_valid` stays 1 and `rd_addr` stays unchanged on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a check; sampled only when idle |
| guest_cr4 | input | 64 | Guest CR4 value (bit 5 selects PAE) |
| ia32e_guest | input | 1 | 64-bit-mode guest entry control |
| prim_ctl | input | 32 | Primary execution-control word |
| sec_ctl | input | 32 | Secondary execution-control word |
| cr3_old | input | 64 | CR3 before entry |
| cr3_new | input | 64 | Guest CR3 to be loaded |
| pae_was_active | input | 1 | PAE paging already in use before entry |
| pa_width | input | 8 | Physical-address width |
| gs_ent | input | 4x64 | Guest-state root entries, index 0 to 3 |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Read request accepted |
| rd_addr | output | 32 | Read byte address |
| rd_rsp_valid | input | 1 | Read data valid |
| rd_rsp_data | input | 64 | Read data |
| done | output | 1 | One-cycle completion strobe |
| fail | output | 1 | Validation failed, valid with `done` |

## Verification
The hardest situation to reach from the ports is a second `start` arriving while a memory fetch is halfway through. It must be ignored, and the fetch already under way must still finish with its own address sequence and verdict. The stimulus launches a memory-route check and, a few cycles later, pulses `start` again with inputs that would select the pass route. The scoreboard then expects exactly one completion, carrying the original verdict and read count. Throughout the run, the read responder stalls `ready` on a rotating pattern and varies the response delay, so that request holding and the timing of `done` after the fourth response are covered under backpressure.

// File: rtl/pae_chk_pkg.sv
package pae_chk_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT} seq_state_t;
  typedef enum logic [1:0] {RT_PASS, RT_FIELDS, RT_MEMORY} route_t;
endpackage

// File: rtl/pae_route_sel.sv
module pae_route_sel
  import pae_chk_pkg::*;
#(
  parameter int CR_W     = 64,
  parameter int CTL_W    = 32,
  parameter int PAE_BIT  = 5,
  parameter int GATE_BIT = 31,
  parameter int NPT_BIT  = 1
) (
  input  logic [CR_W-1:0]  guest_cr4,
  input  logic             ia32e_guest,
  input  logic [CTL_W-1:0] prim_ctl,
  input  logic [CTL_W-1:0] sec_ctl,
  input  logic [CR_W-1:0]  cr3_old,
  input  logic [CR_W-1:0]  cr3_new,
  input  logic             pae_was_active,
  output route_t           route
);
  logic pae_guest;
  logic npt_on;
  logic cr3_moving;

  assign pae_guest  = guest_cr4[PAE_BIT] & ~ia32e_guest;
  // secondary enable only counts when the primary gate bit is set
  assign npt_on     = prim_ctl[GATE_BIT] & sec_ctl[NPT_BIT];
  assign cr3_moving = (cr3_old != cr3_new);

  always_comb begin
    route = RT_PASS;
    if (pae_guest) begin
      if (npt_on)
        route = RT_FIELDS;
      else if (!pae_was_active || cr3_moving)
        route = RT_MEMORY;
    end
  end
endmodule

// File: rtl/pae_entry_eval.sv
module pae_entry_eval #(
  parameter int ENT_W = 64,
  parameter int PAW_W = 8,
  parameter int PG_LO = 12
) (
  input  logic [ENT_W-1:0] entry,
  input  logic [PAW_W-1:0] pa_width,
  output logic             bad
);
  // bits 2:1 and 8:5 are reserved in a present root entry
  localparam logic [ENT_W-1:0] RSV_LOW = ENT_W'(12'h1E6);

  logic [ENT_W-1:0] addr_mask;

  genvar b;
  generate
    for (b = 0; b < ENT_W; b++) begin : g_mask
      if (b >= PG_LO) begin : g_addr
        assign addr_mask[b] = (32'(pa_width) <= b);
      end else begin : g_low
        assign addr_mask[b] = 1'b0;
      end
    end
  endgenerate

  assign bad = entry[0] & (|(entry & (addr_mask | RSV_LOW)));
endmodule

// File: rtl/pae_root_check.sv
module pae_root_check
  import pae_chk_pkg::*;
#(
  parameter int ENT_W    = 64,
  parameter int NUM_ENT  = 4,
  parameter int ADDR_W   = 32,
  parameter int CTL_W    = 32,
  parameter int CR_W     = 64,
  parameter int PAW_W    = 8,
  parameter int PAE_BIT  = 5,
  parameter int GATE_BIT = 31,
  parameter int NPT_BIT  = 1
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          start,
  input  logic [CR_W-1:0]               guest_cr4,
  input  logic                          ia32e_guest,
  input  logic [CTL_W-1:0]              prim_ctl,
  input  logic [CTL_W-1:0]              sec_ctl,
  input  logic [CR_W-1:0]               cr3_old,
  input  logic [CR_W-1:0]               cr3_new,
  input  logic                          pae_was_active,
  input  logic [PAW_W-1:0]              pa_width,
  input  logic [NUM_ENT-1:0][ENT_W-1:0] gs_ent,
  output logic                          rd_req_valid,
  input  logic                          rd_req_ready,
  output logic [ADDR_W-1:0]             rd_addr,
  input  logic                          rd_rsp_valid,
  input  logic [ENT_W-1:0]              rd_rsp_data,
  output logic                          done,
  output logic                          fail
);
  localparam int IDX_W   = $clog2(NUM_ENT);
  localparam int OFF_W   = $clog2(ENT_W / 8);
  localparam int BASE_LO = IDX_W + OFF_W;
  localparam int BASE_W  = ADDR_W - BASE_LO;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_ENT - 1);

  route_t               route;
  seq_state_t           state;
  logic [IDX_W-1:0]     idx;
  logic [IDX_W-1:0]     idx_nxt;
  logic [BASE_W-1:0]    base_q;
  logic [PAW_W-1:0]     paw_q;
  logic                 bad_acc;
  logic                 mem_bad;
  logic [NUM_ENT-1:0]   gs_bad;

  pae_route_sel #(
    .CR_W(CR_W), .CTL_W(CTL_W), .PAE_BIT(PAE_BIT),
    .GATE_BIT(GATE_BIT), .NPT_BIT(NPT_BIT)
  ) u_route (
    .guest_cr4(guest_cr4), .ia32e_guest(ia32e_guest),
    .prim_ctl(prim_ctl), .sec_ctl(sec_ctl),
    .cr3_old(cr3_old), .cr3_new(cr3_new),
    .pae_was_active(pae_was_active), .route(route)
  );

  genvar g;
  generate
    for (g = 0; g < NUM_ENT; g++) begin : g_field
      pae_entry_eval #(.ENT_W(ENT_W), .PAW_W(PAW_W)) u_fev (
        .entry(gs_ent[g]), .pa_width(pa_width), .bad(gs_bad[g])
      );
    end
  endgenerate

  pae_entry_eval #(.ENT_W(ENT_W), .PAW_W(PAW_W)) u_mev (
    .entry(rd_rsp_data), .pa_width(paw_q), .bad(mem_bad)
  );

  assign idx_nxt = idx + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      idx          <= '0;
      base_q       <= '0;
      paw_q        <= '0;
      bad_acc      <= 1'b0;
      rd_req_valid <= 1'b0;
      rd_addr      <= '0;
      done         <= 1'b0;
      fail         <= 1'b0;
    end else begin
      done <= 1'b0;
      fail <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            unique case (route)
              RT_FIELDS: begin
                done <= 1'b1;
                fail <= |gs_bad;
              end
              RT_MEMORY: begin
                base_q       <= cr3_new[ADDR_W-1:BASE_LO];
                paw_q        <= pa_width;
                idx          <= '0;
                bad_acc      <= 1'b0;
                rd_req_valid <= 1'b1;
                rd_addr      <= {cr3_new[ADDR_W-1:BASE_LO], {BASE_LO{1'b0}}};
                state        <= ST_REQ;
              end
              default: done <= 1'b1;
            endcase
          end
        end
        ST_REQ: begin
          if (rd_req_ready) begin
            rd_req_valid <= 1'b0;
            state        <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (rd_rsp_valid) begin
            if (idx == LAST_IDX) begin
              done  <= 1'b1;
              fail  <= bad_acc | mem_bad;
              state <= ST_IDLE;
            end else begin
              idx          <= idx_nxt;
              bad_acc      <= bad_acc | mem_bad;
              rd_req_valid <= 1'b1;
              rd_addr      <= {base_q, idx_nxt, {OFF_W{1'b0}}};
              state        <= ST_REQ;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pae_root_check_sva.sv
module pae_root_check_sva
  import pae_chk_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              cr4_pae,
  input logic              ia32e_guest,
  input logic              rd_req_valid,
  input logic              rd_req_ready,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              rd_rsp_valid,
  input logic              done,
  input logic              fail,
  input seq_state_t        state
);
  // R10
  fail_with_done_chk: assert property (@(posedge clk) disable iff (rst)
    fail |-> done);

  // R12
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_req_valid && !rd_req_ready) |=> (rd_req_valid && $stable(rd_addr)));

  // R4
  addr_align_chk: assert property (@(posedge clk) disable iff (rst)
    rd_req_valid |-> (rd_addr[2:0] == 3'b000));

  // R4
  one_outstanding_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT) |-> !rd_req_valid);

  // R2
  pass_route_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && start && !(cr4_pae && !ia32e_guest))
      |=> (done && !fail && !rd_req_valid));

  // R11
  busy_no_done_chk: assert property (@(posedge clk) disable iff (rst)
    ((state == ST_REQ) || (state == ST_WAIT && !rd_rsp_valid))
      |=> (!done && state != ST_IDLE));
endmodule

bind pae_root_check pae_root_check_sva u_sva (
  .clk(clk), .rst(rst), .start(start), .cr4_pae(guest_cr4[5]),
  .ia32e_guest(ia32e_guest), .rd_req_valid(rd_req_valid),
  .rd_req_ready(rd_req_ready), .rd_addr(rd_addr),
  .rd_rsp_valid(rd_rsp_valid), .done(done), .fail(fail), .state(state)
);

// File: tb/pae_root_check_test.sv
`timescale 1ns/1ps
module pae_root_check_test;
  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start = 1'b0;
  logic [63:0]       guest_cr4 = '0;
  logic              ia32e_guest = 1'b0;
  logic [31:0]       prim_ctl = '0;
  logic [31:0]       sec_ctl = '0;
  logic [63:0]       cr3_old = '0;
  logic [63:0]       cr3_new = '0;
  logic              pae_was_active = 1'b0;
  logic [7:0]        pa_width = 8'd36;
  logic [3:0][63:0]  gs_ent = '0;
  logic              rd_req_valid;
  logic              rd_req_ready = 1'b0;
  logic [31:0]       rd_addr;
  logic              rd_rsp_valid = 1'b0;
  logic [63:0]       rd_rsp_data = '0;
  logic              done;
  logic              fail;

  always #2 clk = ~clk;

  pae_root_check uut (
    .clk(clk), .rst(rst), .start(start), .guest_cr4(guest_cr4),
    .ia32e_guest(ia32e_guest), .prim_ctl(prim_ctl), .sec_ctl(sec_ctl),
    .cr3_old(cr3_old), .cr3_new(cr3_new), .pae_was_active(pae_was_active),
    .pa_width(pa_width), .gs_ent(gs_ent), .rd_req_valid(rd_req_valid),
    .rd_req_ready(rd_req_ready), .rd_addr(rd_addr),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
    .done(done), .fail(fail)
  );

  typedef struct {
    bit    exp_fail;
    int    exp_reads;
    bit    is_mem;
    int    exp_cyc;
    string tag;
  } item_t;

  item_t       sb_q[$];
  int          n_chk = 0;
  int          n_bad = 0;
  int          cyc = 0;
  int          reads_seen = 0;
  int          last_rsp_cyc = 0;
  logic [31:0] exp_base = '0;
  logic [3:0][63:0] tbl = '0;
  bit          finished = 0;

  localparam logic [63:0] GOOD = 64'h0000_0000_1234_5001;
  localparam logic [63:0] JUNK = 64'h0000_0000_0000_01FF;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit ent_bad(input logic [63:0] e, input logic [7:0] paw);
    int lim;
    logic [63:0] hi;
    lim = (paw < 12) ? 12 : int'(paw);
    hi  = (lim >= 64) ? 64'h0 : (e >> lim);
    return e[0] && ((e[2:1] != 0) || (e[8:5] != 0) || (hi != 0));
  endfunction

  // monitor, scoreboard and read responder share one process per negedge
  initial begin : env
    bit          pend = 0;
    int          pend_idx = 0;
    int          delay = 0;
    bit          prev_valid = 0;
    bit          prev_ready = 0;
    logic [31:0] prev_addr = '0;
    forever begin
      @(negedge clk);
      cyc++;
      if (!rst) begin
        if (fail && !done) check(0, "R10 fail without done", 1, 0);
        if (done) begin
          if (sb_q.size() == 0) begin
            check(0, "R11 unexpected done", 1, 0);
          end else begin
            item_t it;
            it = sb_q.pop_front();
            check(fail == it.exp_fail, {it.tag, " verdict"}, fail, it.exp_fail);
            check(reads_seen == it.exp_reads, {it.tag, " read count R4"}, reads_seen, it.exp_reads);
            if (it.is_mem)
              check(cyc == last_rsp_cyc + 1, {it.tag, " R10 done timing"}, cyc, last_rsp_cyc + 1);
            else
              check(cyc == it.exp_cyc, {it.tag, " done timing"}, cyc, it.exp_cyc);
          end
          reads_seen = 0;
        end
        if (prev_valid && !prev_ready)
          check(rd_req_valid && (rd_addr == prev_addr), "R12 request hold", rd_addr, prev_addr);
      end
      rd_rsp_valid = 1'b0;
      if (pend) begin
        if (delay == 0) begin
          rd_rsp_valid = 1'b1;
          rd_rsp_data  = tbl[pend_idx];
          pend = 0;
          last_rsp_cyc = cyc;
        end else begin
          delay--;
        end
      end
      rd_req_ready = ((cyc % 3) != 1);
      if (!rst && rd_req_valid && rd_req_ready) begin
        check(rd_addr == exp_base + 32'(8 * reads_seen), "R4 read address", rd_addr,
              exp_base + 32'(8 * reads_seen));
        pend     = 1;
        pend_idx = reads_seen & 3;
        delay    = cyc % 2;
        reads_seen++;
      end
      prev_valid = rd_req_valid;
      prev_ready = rd_req_ready;
      prev_addr  = rd_addr;
    end
  end

  task automatic pulse_start();
    @(posedge clk); #1;
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
  endtask

  task automatic run_case(input string tag, input bit c5, input bit m64, input bit g31,
                          input bit s1, input bit was, input logic [63:0] old_v,
                          input logic [63:0] new_v, input logic [7:0] paw,
                          input logic [3:0][63:0] ents, input bit inject);
    item_t it;
    bit need, npt, mem;
    bit anyb;
    need = c5 && !m64;
    npt  = g31 && s1;
    mem  = need && !npt && (!was || old_v != new_v);
    anyb = 0;
    for (int k = 0; k < 4; k++) anyb |= ent_bad(ents[k], paw);
    @(posedge clk); #1;
    guest_cr4      = 64'(c5) << 5;
    ia32e_guest    = m64;
    prim_ctl       = 32'(g31) << 31;
    sec_ctl        = 32'(s1) << 1;
    pae_was_active = was;
    cr3_old        = old_v;
    cr3_new        = new_v;
    pa_width       = paw;
    exp_base       = {new_v[31:5], 5'b0};
    gs_ent         = (need && npt) ? ents : {4{JUNK}};
    tbl            = mem ? ents : {4{JUNK}};
    it.exp_fail  = need && (npt || mem) && anyb;
    it.exp_reads = mem ? 4 : 0;
    it.is_mem    = mem;
    it.exp_cyc   = cyc + 2;
    it.tag       = tag;
    sb_q.push_back(it);
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    if (inject) begin
      repeat (2) @(posedge clk);
      #1;
      guest_cr4 = '0;
      pulse_start();
    end
    while (sb_q.size() != 0) @(posedge clk);
    repeat (3) @(posedge clk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", sb_q.size(), 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : driver
    logic [3:0][63:0] e;
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R1
    check(!done && !fail && !rd_req_valid, "R1 reset state", {done, fail, rd_req_valid}, 0);

    e = {4{GOOD}}; e[1] = JUNK;
    run_case("R2 cr4 pae off", 0, 0, 1, 1, 0, 64'h100, 64'h200, 8'd36, e, 0);
    run_case("R2 64-bit guest", 1, 1, 0, 0, 0, 64'h100, 64'h200, 8'd36, e, 0);
    e = {4{GOOD}};
    run_case("R3 fields good", 1, 0, 1, 1, 0, 64'h100, 64'h200, 8'd36, e, 0);
    e = {4{GOOD}}; e[2] = GOOD | (64'h1 << 7);
    run_case("R3 R8 fields bit7", 1, 0, 1, 1, 0, 64'h100, 64'h200, 8'd36, e, 0);
    e = {4{GOOD}}; e[1] = GOOD | (64'h1 << 63);
    run_case("R9 fields bit63", 1, 0, 1, 1, 1, 64'h100, 64'h100, 8'd36, e, 0);
    e = {4{GOOD}};
    run_case("R3 R4 gate off mem", 1, 0, 0, 1, 0, 64'h0000_1234_5678_9AE0,
             64'h0000_1234_5678_9AE0, 8'd36, e, 0);
    e = {4{GOOD}}; e[3] = GOOD | (64'h1 << 40);
    run_case("R4 R9 cr3 moving", 1, 0, 0, 0, 1, 64'h3000, 64'hABCD_E040, 8'd36, e, 0);
    e = {4{JUNK}};
    run_case("R5 same cr3 skip", 1, 0, 0, 0, 1, 64'h5000, 64'h5000, 8'd36, e, 0);
    e = {4{GOOD}}; e[0] = 64'hFFFF_FFFF_FFFF_FFFE;
    run_case("R6 not present", 1, 0, 0, 0, 0, 64'h0, 64'h8000_0020, 8'd36, e, 0);
    e = {4{GOOD | 64'hE18}};
    run_case("R7 ignored bits", 1, 0, 0, 0, 0, 64'h0, 64'h0001_0000, 8'd36, e, 0);
    e = {4{GOOD}}; e[2] = GOOD | (64'h1 << 39);
    run_case("R9 below width", 1, 0, 0, 0, 0, 64'h0, 64'h0002_0000, 8'd40, e, 0);
    e = {4{GOOD}}; e[2] = GOOD | (64'h1 << 40);
    run_case("R9 at width", 1, 0, 0, 0, 0, 64'h0, 64'h0003_0000, 8'd40, e, 0);
    e = {4{GOOD}}; e[0] = GOOD | 64'h2;
    run_case("R8 bit1", 1, 0, 0, 0, 0, 64'h0, 64'h0004_0000, 8'd36, e, 0);
    e = {4{GOOD}};
    run_case("R9 narrow width", 1, 0, 0, 0, 0, 64'h0, 64'h0005_0000, 8'd8, e, 0);
    e = {4{GOOD}}; e[3] = GOOD | 64'h40;
    run_case("R11 start while busy", 1, 0, 0, 0, 0, 64'h0, 64'h0006_0FE0, 8'd36, e, 1);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule